// File: doc/BRIEF.md
# Multi-channel programmable interval timer

This block holds six down-counting timers that share one memory-mapped register interface. Each channel keeps its own control word, interval and live count. The control word picks one of four clock-enable inputs, divides it by a power of two, and runs the channel either once or periodically. When a channel expires it sets its bit in a shared status register. That bit stays set until software writes a one to it. The channel's interrupt line is the status bit ANDed with its bit in a shared enable mask.

Clocks are not generated here. Four single-cycle tick inputs stand in for the clock sources, and a parameter marks which of them exist. Software starts a channel with one write: it sets the interval first, then writes control with the run bit set and the reload bit set. The count register is read-only and always shows the live down-counter.

Top module: `prog_interval_timer`

## Requirements
- R1: After reset, the enable mask, the status register, every interval and every count read zero, every control word reads 0x04 (stopped, source 1, divide by 1), and all interrupt lines are low.
- R2: The enable mask is at byte offset 0x000 and the status register is at 0x004. Channel n (0 to 5) decodes its window at (n+1)*0x10, with control at +0x0, interval at +0x4 and count at +0x8. Any other offset reads zero and ignores writes. Writes to a count offset are ignored.
- R3: Control bit 0 is run, bit 1 is reload, bits [3:2] select the source tick, bits [6:4] give the divide exponent k, and bit 7 selects one-shot (1) or periodic (0). If the selected source is marked absent, the channel never counts.
- R4: A running channel takes one count step for every 2^k ticks of its selected source. A stopped channel holds its count, and ticks on sources it has not selected have no effect.
- R5: A control write with the reload bit set copies the interval into the count and restarts the divider. A control write with reload clear leaves the count unchanged.
- R6: A count step taken while the count is zero is an expiry, and it sets the channel's status bit. In periodic mode the count is reloaded from the interval. In one-shot mode the count stays zero and control bit 0 clears by itself.
- R7: A write to the status register clears each bit written as one and leaves each bit written as zero unchanged.
- R8: Interrupt line n is high exactly when status bit n and enable bit n are both set. It follows a write to either register on the next cycle.
- R9: A read of a count offset returns the current value of the down-counter at the moment of the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_tick | input | 4 | One-cycle enable pulses, one per clock source |
| wr_en | input | 1 | Register write strobe |
| addr | input | 10 | Byte address of the register access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq_o | output | 6 | Per-channel interrupt lines |

## Verification
The bench checks the exact tick on which a periodic channel reloads, with a period of interval+1 steps. A design that reloads on the step that reaches zero would raise its status bit one step early. With divide exponent 2, the bench confirms that three further ticks do not move the count and that the fourth does, which exposes an off-by-one in the divider. After a one-shot expiry it reads control back to confirm the run bit cleared and the count stayed at zero, so a channel that kept running would show up. The bench also clears one status bit while another is set. It selects an absent source, ticks a source the channel has not selected, and writes to the count and unmapped offsets. A design that decoded loosely would show changed state on readback in these cases.

// File: rtl/pit_pkg.sv
package pit_pkg;

  localparam int PRE_W     = 3;
  localparam int PRE_CNT_W = (1 << PRE_W) - 1;
  localparam int SRC_N     = 4;

  typedef struct packed {
    logic             oneshot;
    logic [PRE_W-1:0] pre_exp;
    logic [1:0]       src;
    logic             reload;
    logic             run;
  } pit_ctrl_t;

  localparam pit_ctrl_t CTRL_RESET = pit_ctrl_t'(8'h04);

  typedef enum logic [1:0] {
    REG_NONE,
    REG_CTRL,
    REG_IVAL,
    REG_COUNT
  } chan_reg_e;

  function automatic logic [PRE_CNT_W-1:0] pre_limit(input logic [PRE_W-1:0] k);
    return PRE_CNT_W'((8'd1 << k) - 8'd1);
  endfunction

  function automatic chan_reg_e reg_of(input logic [3:0] nib);
    case (nib)
      4'h0:    return REG_CTRL;
      4'h4:    return REG_IVAL;
      4'h8:    return REG_COUNT;
      default: return REG_NONE;
    endcase
  endfunction

endpackage

// File: rtl/pit_bus_decode.sv
module pit_bus_decode
  import pit_pkg::*;
#(
  parameter int NUM_CH = 6,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  output logic              sel_en,
  output logic              sel_sts,
  output logic [NUM_CH-1:0] sel_ctrl,
  output logic [NUM_CH-1:0] sel_ival,
  output logic [NUM_CH-1:0] sel_cnt
);

  localparam int WIN_W = ADDR_W - 4;

  logic [WIN_W-1:0] win;
  logic [3:0]       nib;
  chan_reg_e        kind;

  assign win  = addr[ADDR_W-1:4];
  assign nib  = addr[3:0];
  assign kind = reg_of(nib);

  assign sel_en  = (win == '0) && (nib == 4'h0);
  assign sel_sts = (win == '0) && (nib == 4'h4);

  for (genvar n = 0; n < NUM_CH; n++) begin : g_win
    logic hit;
    assign hit         = (win == WIN_W'(n + 1));
    assign sel_ctrl[n] = hit && (kind == REG_CTRL);
    assign sel_ival[n] = hit && (kind == REG_IVAL);
    assign sel_cnt[n]  = hit && (kind == REG_COUNT);
  end

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $onehot0({sel_en, sel_sts, sel_ctrl, sel_ival, sel_cnt})); // R2

endmodule

// File: rtl/pit_channel.sv
module pit_channel
  import pit_pkg::*;
#(
  parameter int               CNT_W       = 32,
  parameter logic [SRC_N-1:0] SRC_PRESENT = 4'b0111
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_N-1:0] src_tick,
  input  logic             ctrl_we,
  input  logic             ival_we,
  input  logic [CNT_W-1:0] wdata,
  output pit_ctrl_t        ctrl_q,
  output logic [CNT_W-1:0] ival_q,
  output logic [CNT_W-1:0] count_q,
  output logic             expire_o
);

  logic [PRE_CNT_W-1:0] pre_q;
  logic                 src_ok;
  logic                 tick_sel;
  logic                 pre_wrap;
  logic                 pre_adv;
  logic                 step;
  pit_ctrl_t            ctrl_new;

  assign ctrl_new = pit_ctrl_t'(wdata[7:0]);
  assign src_ok   = SRC_PRESENT[ctrl_q.src];
  assign tick_sel = src_tick[ctrl_q.src] & src_ok;
  assign pre_wrap = (pre_q == pre_limit(ctrl_q.pre_exp));
  assign pre_adv  = ctrl_q.run & tick_sel & ~ctrl_we;
  assign step     = pre_adv & pre_wrap;
  assign expire_o = step & (count_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= CTRL_RESET;
      ival_q  <= '0;
      count_q <= '0;
      pre_q   <= '0;
    end else begin
      if (ival_we) ival_q <= wdata;
      if (ctrl_we) begin
        ctrl_q <= ctrl_new;
        pre_q  <= '0;
        if (ctrl_new.reload) count_q <= ival_q;
      end else begin
        if (pre_adv) pre_q <= pre_wrap ? '0 : pre_q + 1'b1;
        if (step) begin
          if (count_q == '0) begin
            if (ctrl_q.oneshot) ctrl_q.run <= 1'b0;
            else                count_q    <= ival_q;
          end else begin
            count_q <= count_q - 1'b1;
          end
        end
      end
    end
  end

  AST_ONESHOT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_o && ctrl_q.oneshot) |=> (!ctrl_q.run && count_q == '0)); // R6

  AST_PERIODIC_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_o && !ctrl_q.oneshot) |=> (count_q == $past(ival_q))); // R6

  AST_ABSENT_SRC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!src_ok && !ctrl_we) |=> $stable(count_q)); // R3

  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q.run && !ctrl_we) |=> $stable(count_q)); // R4

  AST_RELOAD_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && ctrl_new.reload) |=> (count_q == $past(ival_q))); // R5

endmodule

// File: rtl/pit_irq.sv
module pit_irq #(
  parameter int NUM_CH = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_we,
  input  logic              sts_we,
  input  logic [NUM_CH-1:0] wdata,
  input  logic [NUM_CH-1:0] expire,
  output logic [NUM_CH-1:0] en_q,
  output logic [NUM_CH-1:0] sts_q,
  output logic [NUM_CH-1:0] irq_o
);

  logic [NUM_CH-1:0] clr_mask;

  assign clr_mask = sts_we ? wdata : '0;
  assign irq_o    = sts_q & en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= '0;
      sts_q <= '0;
    end else begin
      if (en_we) en_q <= wdata;
      sts_q <= (sts_q & ~clr_mask) | expire;
    end
  end

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    sts_we |=> ((sts_q & $past(wdata & ~expire)) == '0)); // R7

  AST_ZERO_BITS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    sts_we |=> ((sts_q & $past(sts_q & ~wdata)) == $past(sts_q & ~wdata))); // R7

  AST_EXPIRE_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (|expire) |=> ((sts_q & $past(expire)) == $past(expire))); // R6

endmodule

// File: rtl/prog_interval_timer.sv
module prog_interval_timer
  import pit_pkg::*;
#(
  parameter int               NUM_CH      = 6,
  parameter int               ADDR_W      = 10,
  parameter int               DATA_W      = 32,
  parameter int               CNT_W       = 32,
  parameter logic [SRC_N-1:0] SRC_PRESENT = 4'b0111
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SRC_N-1:0]  src_tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [NUM_CH-1:0] irq_o
);

  logic              sel_en, sel_sts;
  logic [NUM_CH-1:0] sel_ctrl, sel_ival, sel_cnt;
  logic [NUM_CH-1:0] expire, en_q, sts_q;
  pit_ctrl_t         ctrl_a  [NUM_CH];
  logic [CNT_W-1:0]  ival_a  [NUM_CH];
  logic [CNT_W-1:0]  count_a [NUM_CH];

  pit_bus_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .sel_en(sel_en), .sel_sts(sel_sts),
    .sel_ctrl(sel_ctrl), .sel_ival(sel_ival), .sel_cnt(sel_cnt)
  );

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    pit_channel #(.CNT_W(CNT_W), .SRC_PRESENT(SRC_PRESENT)) u_ch (
      .clk(clk), .rst_n(rst_n), .src_tick(src_tick),
      .ctrl_we(wr_en & sel_ctrl[n]), .ival_we(wr_en & sel_ival[n]),
      .wdata(wdata[CNT_W-1:0]),
      .ctrl_q(ctrl_a[n]), .ival_q(ival_a[n]), .count_q(count_a[n]),
      .expire_o(expire[n])
    );
  end

  pit_irq #(.NUM_CH(NUM_CH)) u_irq (
    .clk(clk), .rst_n(rst_n),
    .en_we(wr_en & sel_en), .sts_we(wr_en & sel_sts),
    .wdata(wdata[NUM_CH-1:0]), .expire(expire),
    .en_q(en_q), .sts_q(sts_q), .irq_o(irq_o)
  );

  always_comb begin
    rdata = '0;
    if (sel_en)  rdata = DATA_W'(en_q);
    if (sel_sts) rdata = DATA_W'(sts_q);
    for (int n = 0; n < NUM_CH; n++) begin
      if (sel_ctrl[n]) rdata = DATA_W'(ctrl_a[n]);
      if (sel_ival[n]) rdata = DATA_W'(ival_a[n]);
      if (sel_cnt[n])  rdata = DATA_W'(count_a[n]);
    end
  end

  AST_IRQ_FOLLOWS_STS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel_sts) |=> ((irq_o & $past(wdata[NUM_CH-1:0] & ~expire)) == '0)); // R8

endmodule

// File: tb/prog_interval_timer_test.sv
module prog_interval_timer_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  src_tick = '0;
  logic        wr_en = 1'b0;
  logic [9:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [5:0]  irq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  prog_interval_timer uut (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o)
  );

  always #10 clk = ~clk;

  function automatic logic [9:0] ch_addr(input int ch, input int off);
    return 10'((ch + 1) * 16 + off);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic tick(input int src, input int cnt);
    for (int i = 0; i < cnt; i++) begin
      @(negedge clk); src_tick[src] = 1'b1;
      @(negedge clk); src_tick[src] = 1'b0;
    end
  endtask

  task automatic rd_chk(input string req, input logic [9:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic test_reset;
    rd_chk("R1 enable mask", 10'h000, 0);
    rd_chk("R1 status", 10'h004, 0);
    for (int c = 0; c < 6; c++) begin
      rd_chk("R1 control", ch_addr(c, 0), 32'h04);
      rd_chk("R1 interval", ch_addr(c, 4), 0);
      rd_chk("R1 count", ch_addr(c, 8), 0);
    end
    chk("R1 irq lines", 32'(irq_o), 0);
  endtask

  task automatic test_periodic;
    wr(ch_addr(0, 4), 3);
    wr(ch_addr(0, 0), 32'h07);
    rd_chk("R5 reload loads interval", ch_addr(0, 8), 3);
    tick(1, 3);
    rd_chk("R4 counted to zero", ch_addr(0, 8), 0);
    rd_chk("R6 no expiry before step at zero", 10'h004, 0);
    tick(1, 1);
    rd_chk("R6 periodic expiry sets status", 10'h004, 1);
    rd_chk("R6 periodic reload", ch_addr(0, 8), 3);
    wr(ch_addr(0, 0), 32'h04);
    rd_chk("R5 no reload keeps count", ch_addr(0, 8), 3);
    tick(1, 2);
    rd_chk("R4 stopped channel holds", ch_addr(0, 8), 3);
  endtask

  task automatic test_oneshot;
    wr(ch_addr(1, 4), 2);
    wr(ch_addr(1, 0), 32'h87);
    tick(1, 3);
    rd_chk("R6 one-shot status", 10'h004, 3);
    rd_chk("R6 one-shot clears run bit", ch_addr(1, 0), 32'h86);
    rd_chk("R6 one-shot count stays zero", ch_addr(1, 8), 0);
    tick(1, 2);
    rd_chk("R6 one-shot stays stopped", ch_addr(1, 8), 0);
  endtask

  task automatic test_irq;
    chk("R8 masked lines low", 32'(irq_o), 0);
    wr(10'h000, 3);
    rd_chk("R2 enable readback", 10'h000, 3);
    chk("R8 both lines high", 32'(irq_o), 3);
    wr(10'h004, 1);
    rd_chk("R7 one bit cleared, other kept", 10'h004, 2);
    chk("R8 line follows status", 32'(irq_o), 2);
    wr(10'h000, 1);
    chk("R8 line follows enable", 32'(irq_o), 0);
    wr(10'h004, 2);
    rd_chk("R7 last bit cleared", 10'h004, 0);
  endtask

  task automatic test_prescale;
    wr(ch_addr(2, 4), 10);
    wr(ch_addr(2, 0), 32'h27);
    tick(1, 4);
    rd_chk("R4 divide by 4 first step", ch_addr(2, 8), 9);
    tick(1, 3);
    rd_chk("R4 divide by 4 holds", ch_addr(2, 8), 9);
    tick(1, 1);
    rd_chk("R4 divide by 4 second step", ch_addr(2, 8), 8);
    wr(ch_addr(2, 0), 32'h24);
  endtask

  task automatic test_sources;
    wr(ch_addr(3, 4), 5);
    wr(ch_addr(3, 0), 32'h0F);
    tick(3, 6);
    rd_chk("R3 absent source never counts", ch_addr(3, 8), 5);
    rd_chk("R3 absent source no status", 10'h004, 0);
    wr(ch_addr(3, 0), 32'h0C);
    wr(ch_addr(4, 4), 5);
    wr(ch_addr(4, 0), 32'h03);
    tick(1, 3);
    rd_chk("R4 unselected source ignored", ch_addr(4, 8), 5);
    tick(0, 2);
    rd_chk("R3 source 0 selected counts", ch_addr(4, 8), 3);
    wr(ch_addr(4, 0), 32'h00);
  endtask

  task automatic test_unmapped;
    wr(10'h008, 32'hFFFF_FFFF);
    rd_chk("R2 unmapped global reads zero", 10'h008, 0);
    rd_chk("R2 unmapped write left mask", 10'h000, 1);
    wr(ch_addr(4, 12), 32'h1234);
    rd_chk("R2 unmapped channel slot", ch_addr(4, 12), 0);
    wr(ch_addr(4, 8), 32'h55);
    rd_chk("R2 count write ignored", ch_addr(4, 8), 3);
    wr(10'h070, 32'h07);
    rd_chk("R2 window past last channel", 10'h070, 0);
    wr(10'h3F0, 32'h07);
    rd_chk("R2 top window", 10'h3F0, 0);
    rd_chk("R2 status untouched", 10'h004, 0);
  endtask

  task automatic test_live;
    wr(ch_addr(5, 4), 100);
    wr(ch_addr(5, 0), 32'h07);
    tick(1, 1);
    rd_chk("R9 live count", ch_addr(5, 8), 99);
    tick(1, 1);
    rd_chk("R9 live count again", ch_addr(5, 8), 98);
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_periodic();
    test_oneshot();
    test_irq();
    test_prescale();
    test_sources();
    test_unmapped();
    test_live();
    done = 1;
    summary();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
    end
  end

endmodule